// File: doc/BRIEF.md
# T1 Transmit Frame Marker Generator

This block produces the timing strobes that a T1 transmit system interface needs to place data and signaling at the right bit positions. It advances one position per bit clock through a 193-bit frame. Each frame is one framing bit followed by 24 channels of 8 bits. Above the frame level it keeps a 12-frame group count, a superframe count whose length follows the framing format (12, 24 or 72 frames), and a separate multiframe count whose length is a parameter. A frame-sync input forces the position to frame 1, bit 0 at any time, so the marker phase follows the system alignment.

The block drives two outputs. The begin strobe is one bit period long and marks either the start of every multiframe or the start of every 12-frame group. In the 12-frame format a group is the whole superframe; in the 24- and 72-frame formats the group starts give the extra pulses inside each superframe. The signaling marker is high on every bit of each channel selected by a 24-bit mask. When robbed-bit marking is on, it is also high on the last bit of every channel in the sixth and twelfth frame of each 12-frame group. The configuration inputs are copied into an active set only at frame sync or at the end of a superframe, so a change never produces a shortened superframe.

The position tracker is a two-state machine. `ST_FBIT` covers the framing bit and `ST_CHAN` covers the 192 channel bits. The transitions are: `ST_FBIT` to `ST_CHAN` after the single framing bit; `ST_CHAN` to `ST_CHAN` while channel bits remain; `ST_CHAN` to `ST_FBIT` after bit 8 of channel 24; and any state to `ST_FBIT` when frame sync is sampled high.

Top module: `t1m_marker_top`

## Requirements
- R1: Asynchronous reset puts the position at frame 1, bit 0 (`ST_FBIT`) with an all-zero active configuration: the first cycle after reset has `mf_begin`=1 and `sig_mark`=0.
- R2: With `cfg_mf_mode`=0, `mf_begin` is high at bit 0 of frames 1, 13, 25, ... counted from alignment, and low otherwise. In the 12-frame format (`cfg_fmt`=0, and also 3) this is every superframe start.
- R3: `cfg_fmt`=1 selects a 24-frame superframe and `cfg_fmt`=2 selects a 72-frame superframe. In these formats the begin pulses still come every 12 frames, and configuration loads only at the end of the superframe length in force.
- R4: With `cfg_mf_mode`=1, `mf_begin` is high at bit 0 of frame 1 of each multiframe of `MF_FRAMES` frames (default 16), counted from alignment.
- R5: `mf_begin` is never high for two bit periods in a row unless frame sync is applied.
- R6: `sig_mark` is high on all 8 bits of channel k+1 whenever active mask bit k is 1. Bit 0 is the first channel after the framing bit.
- R7: `sig_mark` is never high on the framing bit.
- R8: With robbed-bit marking active, `sig_mark` is also high on bit 8 (the last bit) of every channel in frames 6 and 12 of each 12-frame group.
- R9: Frame sync sampled high on a clock edge makes the next bit frame 1, bit 0, from any position.
- R10: Changes on the configuration inputs take effect only from the first bit after a superframe ends or after frame sync.
- R11: With robbed-bit marking inactive, only mask-selected channels are marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one edge per transmitted bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Synchronous realignment to frame 1, bit 0 |
| cfg_mf_mode | input | 1 | 1: mark multiframe starts; 0: mark 12-frame group starts |
| cfg_fmt | input | 2 | Framing format: 0 = 12-frame, 1 = 24-frame, 2 = 72-frame, 3 = 12-frame |
| cfg_ts_mask | input | 24 | Timeslot selection, bit k = channel k+1 |
| cfg_rb_en | input | 1 | Robbed-bit marking enable |
| mf_begin | output | 1 | Begin strobe, one bit period |
| sig_mark | output | 1 | Signaling marker, per bit |

## Verification
On every cycle, the assertions check the following. Frame sync lands the counters on frame 1, bit 0. The superframe wraps to frame 1 at the length in force. The active configuration holds between load points. The begin strobe never lasts two bits. A mask-driven mark covers the rest of its channel. Only the bench's scenarios can show the absolute positions of the marks: the 12-frame pulse spacing in each format, the multiframe spacing, the robbed-bit frames 6 and 12, and the exact superframe at which a changed configuration first appears. The bench compares each bit against a position model that counts from alignment.

// File: rtl/t1m_pkg.sv
package t1m_pkg;

    // Framing structure constants
    localparam int unsigned GRP_FRAMES = 12;  // begin-pulse spacing in mode 0
    localparam int unsigned RB_SPACING = 6;   // robbed bit every sixth frame
    localparam int unsigned SF_LEN_W   = 7;   // wide enough for 72

    typedef enum logic {
        ST_FBIT = 1'b0,
        ST_CHAN = 1'b1
    } pos_state_e;

    typedef struct packed {
        logic       mf_mode;
        logic [1:0] fmt;
        logic       rb_en;
    } mark_ctl_t;

    function automatic logic [SF_LEN_W-1:0] sf_len(input logic [1:0] fmt);
        unique case (fmt)
            2'd1:    sf_len = SF_LEN_W'(24);
            2'd2:    sf_len = SF_LEN_W'(72);
            default: sf_len = SF_LEN_W'(12);
        endcase
    endfunction

endpackage

// File: rtl/t1m_cfg_latch.sv
module t1m_cfg_latch
    import t1m_pkg::*;
#(
    parameter int unsigned NUM_CH = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  mark_ctl_t         ctl_in,
    input  logic [NUM_CH-1:0] mask_in,
    output mark_ctl_t         ctl_act,
    output logic [NUM_CH-1:0] mask_act
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_act  <= '0;
            mask_act <= '0;
        end else if (load) begin
            ctl_act  <= ctl_in;
            mask_act <= mask_in;
        end
    end

    // R10: active configuration moves only at a load point
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(ctl_act) && $stable(mask_act)));

endmodule

// File: rtl/t1m_position.sv
module t1m_position
    import t1m_pkg::*;
#(
    parameter int unsigned NUM_CH    = 24,
    parameter int unsigned CH_BITS   = 8,
    parameter int unsigned MF_FRAMES = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fsync,
    input  logic [1:0]                     fmt,
    output logic                           in_fbit,
    output logic [$clog2(NUM_CH)-1:0]      ch_idx,
    output logic [$clog2(CH_BITS)-1:0]     bit_idx,
    output logic [$clog2(GRP_FRAMES+1)-1:0] grp_frm,
    output logic                           mf_first,
    output logic                           sf_end
);

    localparam int unsigned CW = $clog2(NUM_CH);
    localparam int unsigned BW = $clog2(CH_BITS);
    localparam int unsigned GW = $clog2(GRP_FRAMES + 1);
    localparam int unsigned MW = $clog2(MF_FRAMES + 1);

    pos_state_e            state_q, state_d;
    logic [CW-1:0]         ch_q;
    logic [BW-1:0]         bit_q;
    logic [SF_LEN_W-1:0]   frm_q;
    logic [GW-1:0]         grp_q;
    logic [MW-1:0]         mf_q;
    logic [SF_LEN_W-1:0]   frm_len;
    logic                  ch_last_bit;
    logic                  frame_last;

    assign frm_len     = sf_len(fmt);
    assign ch_last_bit = (bit_q == BW'(CH_BITS - 1));
    assign frame_last  = (state_q == ST_CHAN) && ch_last_bit
                         && (ch_q == CW'(NUM_CH - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FBIT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FBIT: state_d = ST_CHAN;
            ST_CHAN: state_d = frame_last ? ST_FBIT : ST_CHAN;
        endcase
        if (fsync) state_d = ST_FBIT;
    end

    // Position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= '0;
            bit_q <= '0;
            frm_q <= SF_LEN_W'(1);
            grp_q <= GW'(1);
            mf_q  <= MW'(1);
        end else if (fsync) begin
            ch_q  <= '0;
            bit_q <= '0;
            frm_q <= SF_LEN_W'(1);
            grp_q <= GW'(1);
            mf_q  <= MW'(1);
        end else if (state_q == ST_CHAN) begin
            if (ch_last_bit) begin
                bit_q <= '0;
                ch_q  <= frame_last ? '0 : ch_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
            if (frame_last) begin
                frm_q <= (frm_q >= frm_len) ? SF_LEN_W'(1) : frm_q + 1'b1;
                grp_q <= (grp_q == GW'(GRP_FRAMES)) ? GW'(1) : grp_q + 1'b1;
                mf_q  <= (mf_q == MW'(MF_FRAMES)) ? MW'(1) : mf_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        in_fbit  = (state_q == ST_FBIT);
        ch_idx   = ch_q;
        bit_idx  = bit_q;
        grp_frm  = grp_q;
        mf_first = (mf_q == MW'(1));
        sf_end   = frame_last && (frm_q >= frm_len);
    end

    // R9: frame sync lands on frame 1, bit 0
    p_fsync_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (state_q == ST_FBIT && frm_q == SF_LEN_W'(1)
                   && grp_q == GW'(1) && mf_q == MW'(1)));

    // R3: superframe wraps to frame 1 at its end
    p_sf_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_end && !fsync) |=> (state_q == ST_FBIT && frm_q == SF_LEN_W'(1)));

endmodule

// File: rtl/t1m_marker.sv
module t1m_marker
    import t1m_pkg::*;
#(
    parameter int unsigned NUM_CH  = 24,
    parameter int unsigned CH_BITS = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fsync,
    input  mark_ctl_t                       ctl,
    input  logic [NUM_CH-1:0]               mask,
    input  logic                            in_fbit,
    input  logic [$clog2(NUM_CH)-1:0]       ch_idx,
    input  logic [$clog2(CH_BITS)-1:0]      bit_idx,
    input  logic [$clog2(GRP_FRAMES+1)-1:0] grp_frm,
    input  logic                            mf_first,
    output logic                            begin_o,
    output logic                            mark_o
);

    localparam int unsigned BW = $clog2(CH_BITS);
    localparam int unsigned GW = $clog2(GRP_FRAMES + 1);

    logic rb_frame;
    logic rb_pos;

    always_comb begin
        rb_frame = (grp_frm == GW'(RB_SPACING)) || (grp_frm == GW'(2 * RB_SPACING));
        rb_pos   = ctl.rb_en && rb_frame && (bit_idx == BW'(CH_BITS - 1));
        begin_o  = in_fbit && (ctl.mf_mode ? mf_first : (grp_frm == GW'(1)));
        mark_o   = !in_fbit && (mask[ch_idx] || rb_pos);
    end

    // R5: begin strobe lasts one bit period
    p_begin_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (begin_o && !fsync) |=> !begin_o);

    // R6: a mask mark before the last bit continues into the next bit
    p_mark_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_o && bit_idx != BW'(CH_BITS - 1) && !fsync) |=> mark_o);

endmodule

// File: rtl/t1m_marker_top.sv
module t1m_marker_top
    import t1m_pkg::*;
#(
    parameter int unsigned NUM_CH    = 24,
    parameter int unsigned CH_BITS   = 8,
    parameter int unsigned MF_FRAMES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              cfg_mf_mode,
    input  logic [1:0]        cfg_fmt,
    input  logic [NUM_CH-1:0] cfg_ts_mask,
    input  logic              cfg_rb_en,
    output logic              mf_begin,
    output logic              sig_mark
);

    localparam int unsigned CW = $clog2(NUM_CH);
    localparam int unsigned BW = $clog2(CH_BITS);
    localparam int unsigned GW = $clog2(GRP_FRAMES + 1);

    mark_ctl_t         ctl_in, ctl_act;
    logic [NUM_CH-1:0] mask_act;
    logic              in_fbit, mf_first, sf_end;
    logic [CW-1:0]     ch_idx;
    logic [BW-1:0]     bit_idx;
    logic [GW-1:0]     grp_frm;

    assign ctl_in = '{mf_mode: cfg_mf_mode, fmt: cfg_fmt, rb_en: cfg_rb_en};

    t1m_cfg_latch #(.NUM_CH(NUM_CH)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_sync | sf_end),
        .ctl_in   (ctl_in),
        .mask_in  (cfg_ts_mask),
        .ctl_act  (ctl_act),
        .mask_act (mask_act)
    );

    t1m_position #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS), .MF_FRAMES(MF_FRAMES)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (frame_sync),
        .fmt      (ctl_act.fmt),
        .in_fbit  (in_fbit),
        .ch_idx   (ch_idx),
        .bit_idx  (bit_idx),
        .grp_frm  (grp_frm),
        .mf_first (mf_first),
        .sf_end   (sf_end)
    );

    t1m_marker #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS)) u_mark (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (frame_sync),
        .ctl      (ctl_act),
        .mask     (mask_act),
        .in_fbit  (in_fbit),
        .ch_idx   (ch_idx),
        .bit_idx  (bit_idx),
        .grp_frm  (grp_frm),
        .mf_first (mf_first),
        .begin_o  (mf_begin),
        .mark_o   (sig_mark)
    );

endmodule

// File: tb/t1m_marker_top_bench.sv
module t1m_marker_top_bench;

    localparam int FBITS = 193;
    localparam int MFN   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        cfg_mf_mode = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [23:0] cfg_ts_mask = '0;
    logic        cfg_rb_en = 1'b0;
    logic        mf_begin, sig_mark;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Position and configuration model
    int          n = 0;
    int          sf_base = 0;
    logic        a_mode = 0, p_mode = 0;
    logic [1:0]  a_fmt = 0,  p_fmt = 0;
    logic [23:0] a_mask = 0, p_mask = 0;
    logic        a_rb = 0,   p_rb = 0;

    always #5 clk = ~clk;

    t1m_marker_top u_t1m_marker_top (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .cfg_mf_mode(cfg_mf_mode), .cfg_fmt(cfg_fmt),
        .cfg_ts_mask(cfg_ts_mask), .cfg_rb_en(cfg_rb_en),
        .mf_begin(mf_begin), .sig_mark(sig_mark)
    );

    function automatic int len_of(input logic [1:0] f);
        return (f == 2'd1) ? 24 : (f == 2'd2) ? 72 : 12;
    endfunction

    function automatic logic exp_begin(input int pos);
        int b, f0;
        b  = pos % FBITS;
        f0 = pos / FBITS;
        if (b != 0) return 1'b0;
        return a_mode ? ((f0 % MFN) == 0) : ((f0 % 12) == 0);
    endfunction

    function automatic logic exp_mark(input int pos);
        int b, f0, ch, bi;
        b  = pos % FBITS;
        f0 = pos / FBITS;
        if (b == 0) return 1'b0;
        ch = (b - 1) / 8;
        bi = (b - 1) % 8;
        return a_mask[ch] | (a_rb && bi == 7 && ((f0 % 12) == 5 || (f0 % 12) == 11));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic set_inputs(input logic m, input logic [1:0] f,
                              input logic [23:0] k, input logic r);
        cfg_mf_mode = m; cfg_fmt = f; cfg_ts_mask = k; cfg_rb_en = r;
        p_mode = m; p_fmt = f; p_mask = k; p_rb = r;
    endtask

    // Called at a negedge: pulse frame sync, model restarts at position 0
    task automatic align(input logic m, input logic [1:0] f,
                         input logic [23:0] k, input logic r);
        set_inputs(m, f, k, r);
        frame_sync = 1'b1;
        @(posedge clk); @(negedge clk);
        frame_sync = 1'b0;
        a_mode = m; a_fmt = f; a_mask = k; a_rb = r;
        n = 0; sf_base = 0;
    endtask

    // Compare both outputs bit by bit for a number of frames
    task automatic scan(input int frames, input string tag_b, input string tag_m);
        int bad_b = 0, bad_m = 0;
        int fb_n = -1, fm_n = -1;
        logic fb_a = 0, fb_e = 0, fm_a = 0, fm_e = 0;
        for (int i = 0; i < frames * FBITS; i++) begin
            if (mf_begin !== exp_begin(n)) begin
                if (bad_b == 0) begin fb_n = n; fb_a = mf_begin; fb_e = exp_begin(n); end
                bad_b++;
            end
            if (sig_mark !== exp_mark(n)) begin
                if (bad_m == 0) begin fm_n = n; fm_a = sig_mark; fm_e = exp_mark(n); end
                bad_m++;
            end
            @(posedge clk); @(negedge clk);
            n++;
            if (n - sf_base == FBITS * len_of(a_fmt)) begin
                sf_base = n;
                a_mode = p_mode; a_fmt = p_fmt; a_mask = p_mask; a_rb = p_rb;
            end
        end
        check(bad_b == 0, $sformatf("%s mf_begin at pos %0d", tag_b, fb_n), int'(fb_a), int'(fb_e));
        check(bad_m == 0, $sformatf("%s sig_mark at pos %0d", tag_m, fm_n), int'(fm_a), int'(fm_e));
    endtask

    // R1 and R10: reset state, inputs held off until the first superframe ends
    task automatic t_reset;
        set_inputs(1'b0, 2'd0, 24'hFFFFFF, 1'b1);
        a_mode = 0; a_fmt = 0; a_mask = 0; a_rb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0; sf_base = 0;
        check(mf_begin === 1'b1, "R1 mf_begin after reset", int'(mf_begin), 1);
        check(sig_mark === 1'b0, "R1 sig_mark after reset", int'(sig_mark), 0);
        scan(14, "R1", "R10");
    endtask

    // R2, R6, R7, R11: 12-frame format, edge channels, no robbed bits
    task automatic t_sf_mask;
        align(1'b0, 2'd0, 24'h800001, 1'b0);
        scan(13, "R2", "R6 R7 R11");
    endtask

    // R3 and R8: 24-frame format with robbed-bit marking
    task automatic t_esf_rb;
        align(1'b0, 2'd1, 24'h00F0F0, 1'b1);
        scan(25, "R3", "R8");
    endtask

    // R3 and R10: 72-frame format, change requested mid-superframe
    task automatic t_f72_change;
        align(1'b0, 2'd2, 24'h000000, 1'b1);
        scan(30, "R3", "R8");
        set_inputs(1'b0, 2'd0, 24'h5A5A5A, 1'b0);
        scan(50, "R3", "R10");
    endtask

    // R4: multiframe marking
    task automatic t_mf_mode;
        align(1'b1, 2'd0, 24'h000100, 1'b0);
        scan(33, "R4", "R6");
    endtask

    // R9: realignment from mid-frame
    task automatic t_realign;
        repeat (77) @(posedge clk);
        @(negedge clk);
        align(1'b0, 2'd1, 24'h0C0003, 1'b0);
        check(mf_begin === 1'b1, "R9 mf_begin right after frame sync", int'(mf_begin), 1);
        check(sig_mark === 1'b0, "R9 framing bit after frame sync", int'(sig_mark), 0);
        scan(3, "R9", "R9");
    endtask

    initial begin
        t_reset();
        t_sf_mask();
        t_esf_rb();
        t_f72_change();
        t_mf_mode();
        t_realign();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule